// File: doc/BRIEF.md
# Timer Clock Source Selector

This block decides, once per system clock cycle, whether a timer/counter may advance. A 3-bit source code chooses one of eight behaviours. The timer can be halted. It can advance on every cycle. It can advance at one of four divided rates taken from a shared free-running prescaler. It can also advance on the rising or falling transitions of an asynchronous external pin. The result is a one-cycle count-enable strobe that is synchronous to the system clock. The counter it drives lies outside the block.

The block has no data stream, so all of its pins are plain control pins with no valid/ready handshake. The source code is registered, so a new code governs the strobe from the next clock edge onward. A strobe on the prescaler-restart input clears the shared divider, which lets software align the first divided count. The external pin is always synchronized and edge-detected, whatever the direction the surrounding logic gives that pin. A pin driven by the chip itself can therefore still advance the timer.

Top module: `tmr_clk_sel`

## Requirements
- R1: While `rst_n` is low, `cnt_en` is 0 whatever `src_sel` holds. The source register resets to code 000 (halted). The prescaler and pin synchronizer also clear on reset.
- R2: With code 000 sampled, `cnt_en` stays 0 on every cycle.
- R3: With code 001 sampled, `cnt_en` is 1 on every cycle.
- R4: Codes 010, 011 and 100 give one `cnt_en` pulse every 8, 64 and 256 cycles. Each pulse comes when the low 3, 6 or 8 bits of the shared 10-bit prescaler are all ones.
- R5: Code 101 gives one `cnt_en` pulse every 1024 cycles, when all 10 prescaler bits are ones.
- R6: In a cycle where `psc_restart` is 1, no divided pulse is produced and the prescaler clears. For a divide ratio N, the next divided pulse then falls exactly N cycles after that cycle.
- R7: With code 111, each rising transition of `ext_clk` gives exactly one `cnt_en` pulse. The pulse is seen in the cycle after the second clock edge that samples the new pin level. Falling transitions give no pulse.
- R8: With code 110, each falling transition of `ext_clk` gives exactly one pulse, with the same latency as R7. Rising transitions give no pulse.
- R9: `psc_restart` has no effect on the code 001 strobe or on the external-edge pulses.
- R10: A code applied before a clock edge takes effect from that edge. A switch between divided codes adds no pulse of its own: afterwards, pulses come only at the new tap's prescaler phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset, synchronous to clk |
| src_sel | input | 3 | Count source code (000 halt, 001 /1, 010 /8, 011 /64, 100 /256, 101 /1024, 110 pin falling, 111 pin rising) |
| psc_restart | input | 1 | One-cycle strobe that clears the shared prescaler |
| ext_clk | input | 1 | Asynchronous external count pin |
| cnt_en | output | 1 | Count-enable strobe for the timer |

## Verification
The hardest behaviour to reach from the ports is the phase of the divided taps after a source change. The prescaler is free-running and cannot be seen from outside, so the bench first pulses `psc_restart` to fix its phase. It then changes the code partway through a /8 run to /1024 and predicts every later cycle from its own cycle count since the restart. Any extra strobe or shifted phase shows up as a mismatch. The external-edge latency is pinned down the same way: the pin is changed on a falling clock edge, and the single strobe is expected on one exact sample.

// File: rtl/tcs_pkg.sv
package tcs_pkg;

  typedef enum logic [2:0] {
    SRC_OFF      = 3'b000,
    SRC_DIV1     = 3'b001,
    SRC_DIV8     = 3'b010,
    SRC_DIV64    = 3'b011,
    SRC_DIV256   = 3'b100,
    SRC_DIV1024  = 3'b101,
    SRC_EXT_FALL = 3'b110,
    SRC_EXT_RISE = 3'b111
  } src_e;

  localparam int unsigned PSC_W  = 10;
  localparam int unsigned N_TAPS = 4;
  // log2 of each divide ratio, index 0 = /8 .. index 3 = /1024
  localparam int unsigned TAP_LOG2 [N_TAPS] = '{3, 6, 8, 10};
  localparam int unsigned SYNC_STAGES = 2;

endpackage

// File: rtl/tcs_prescaler.sv
module tcs_prescaler
  import tcs_pkg::*;
#(
  parameter int unsigned CNT_W = PSC_W,
  parameter int unsigned NT    = N_TAPS
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          restart,
  output logic [NT-1:0] tap
);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n)       cnt_q <= '0;
    else if (restart) cnt_q <= '0;
    else              cnt_q <= cnt_q + 1'b1;
  end

  for (genvar g = 0; g < NT; g++) begin : g_tap
    localparam int unsigned LB = TAP_LOG2[g];
    assign tap[g] = !restart && (&cnt_q[LB-1:0]);
  end

  // R6: the cycle after a restart the finest tap cannot fire
  a_r6_quiet_after_restart: assert property (@(posedge clk) disable iff (!rst_n)
    restart |=> !tap[0]);

  // R4: a coarser tap only fires together with every finer tap
  for (genvar g = 0; g + 1 < NT; g++) begin : g_nest
    a_r4_tap_nesting: assert property (@(posedge clk) disable iff (!rst_n)
      tap[g+1] |-> tap[g]);
  end

  // R4: the /8 tap never fires on two consecutive cycles
  a_r4_tap_spacing: assert property (@(posedge clk) disable iff (!rst_n)
    tap[0] |=> !tap[0]);

endmodule

// File: rtl/tcs_pin_edge.sv
module tcs_pin_edge
  import tcs_pkg::*;
#(
  parameter int unsigned STAGES = SYNC_STAGES
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin,
  output logic rise,
  output logic fall
);

  localparam int unsigned CHAIN = STAGES + 1;

  logic [CHAIN-1:0] sync_q;
  logic [CHAIN-1:0] arm_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sync_q <= '0;
      arm_q  <= '0;
    end else begin
      sync_q <= {sync_q[CHAIN-2:0], pin};
      arm_q  <= {arm_q[CHAIN-2:0], 1'b1};
    end
  end

  logic armed;
  assign armed = arm_q[CHAIN-1];
  assign rise  = armed &&  sync_q[CHAIN-2] && !sync_q[CHAIN-1];
  assign fall  = armed && !sync_q[CHAIN-2] &&  sync_q[CHAIN-1];

  // R7/R8: one transition gives one pulse, never both polarities together
  a_r7_exclusive_edges: assert property (@(posedge clk) disable iff (!rst_n)
    !(rise && fall));
  a_r7_single_rise: assert property (@(posedge clk) disable iff (!rst_n)
    rise |=> !rise);
  a_r8_single_fall: assert property (@(posedge clk) disable iff (!rst_n)
    fall |=> !fall);

endmodule

// File: rtl/tcs_src_mux.sv
module tcs_src_mux
  import tcs_pkg::*;
#(
  parameter int unsigned NT = N_TAPS
) (
  input  src_e          src,
  input  logic [NT-1:0] tap,
  input  logic          rise,
  input  logic          fall,
  output logic          en
);

  always_comb begin
    unique case (src)
      SRC_OFF:      en = 1'b0;
      SRC_DIV1:     en = 1'b1;
      SRC_DIV8:     en = tap[0];
      SRC_DIV64:    en = tap[1];
      SRC_DIV256:   en = tap[2];
      SRC_DIV1024:  en = tap[3];
      SRC_EXT_FALL: en = fall;
      SRC_EXT_RISE: en = rise;
      default:      en = 1'b0;
    endcase
  end

endmodule

// File: rtl/tmr_clk_sel.sv
module tmr_clk_sel
  import tcs_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic [2:0] src_sel,
  input  logic       psc_restart,
  input  logic       ext_clk,
  output logic       cnt_en
);

  src_e              src_q;
  logic [N_TAPS-1:0] tap;
  logic              pin_rise;
  logic              pin_fall;
  logic              en_raw;

  always_ff @(posedge clk) begin
    if (!rst_n) src_q <= SRC_OFF;
    else        src_q <= src_e'(src_sel);
  end

  tcs_prescaler #(.CNT_W(PSC_W), .NT(N_TAPS)) u_psc (
    .clk     (clk),
    .rst_n   (rst_n),
    .restart (psc_restart),
    .tap     (tap)
  );

  tcs_pin_edge #(.STAGES(SYNC_STAGES)) u_edge (
    .clk   (clk),
    .rst_n (rst_n),
    .pin   (ext_clk),
    .rise  (pin_rise),
    .fall  (pin_fall)
  );

  tcs_src_mux #(.NT(N_TAPS)) u_mux (
    .src  (src_q),
    .tap  (tap),
    .rise (pin_rise),
    .fall (pin_fall),
    .en   (en_raw)
  );

  assign cnt_en = rst_n && en_raw;

  // R1: no strobe while reset is held
  always_comb begin
    if (!rst_n) a_r1_reset_quiet: assert (!cnt_en);
  end

  // R2: halted source never strobes
  a_r2_off_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (src_q == SRC_OFF) |-> !cnt_en);

  // R3: undivided source strobes every cycle, restart or not (R9)
  a_r3_div1_every: assert property (@(posedge clk) disable iff (!rst_n)
    (src_q == SRC_DIV1) |-> cnt_en);

  // R10: a divided strobe never appears on two consecutive cycles
  a_r10_div_no_double: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_en && src_q inside {SRC_DIV8, SRC_DIV64, SRC_DIV256, SRC_DIV1024}
     && $stable(src_q)) |=> !(cnt_en && src_q != SRC_DIV1));

endmodule

// File: tb/tb_tmr_clk_sel.sv
module tb_tmr_clk_sel;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [2:0] src_sel = 3'b000;
  logic       psc_restart = 1'b0;
  logic       ext_clk = 1'b0;
  logic       cnt_en;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 1'b0;

  always #10 clk = ~clk;

  tmr_clk_sel dut (
    .clk         (clk),
    .rst_n       (rst_n),
    .src_sel     (src_sel),
    .psc_restart (psc_restart),
    .ext_clk     (ext_clk),
    .cnt_en      (cnt_en)
  );

  task automatic check(input string req, input logic act, input logic exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: cnt_en=%0b expected %0b", req, act, exp);
    end
  endtask

  // Window: restart prescaler, run code1 until sample sw_k, then code2.
  task automatic div_window(input string req, input logic [2:0] code1,
                            input int n1, input int sw_k,
                            input logic [2:0] code2, input int n2, input int len);
    int bad = 0;
    int first_k = -1;
    logic first_act = 1'b0;
    logic first_exp = 1'b0;
    @(negedge clk);
    src_sel = code1;
    psc_restart = 1'b1;
    for (int k = 1; k <= len; k++) begin
      @(negedge clk);
      psc_restart = 1'b0;
      begin
        logic exp;
        if (k <= sw_k) exp = (n1 == 0) ? 1'b0 : ((k % n1) == 0);
        else           exp = (n2 == 0) ? 1'b0 : ((k % n2) == 0);
        if (cnt_en !== exp) begin
          if (bad == 0) begin
            first_k = k; first_act = cnt_en; first_exp = exp;
          end
          bad++;
        end
      end
      if (k == sw_k) src_sel = code2;
    end
    n_tests++;
    if (bad != 0) begin
      n_fail++;
      $display("FAIL %s: sample %0d cnt_en=%0b expected %0b (%0d mismatches)",
               req, first_k, first_act, first_exp, bad);
    end
  endtask

  task automatic t_reset;
    src_sel = 3'b001;
    repeat (3) @(negedge clk);
    check("R1 held in reset", cnt_en, 1'b0);
    rst_n = 1'b1;
    check("R1 before first edge", cnt_en, 1'b0);
    @(negedge clk);
    check("R10 code applied at first edge", cnt_en, 1'b1);
    src_sel = 3'b000;
    @(negedge clk);
  endtask

  task automatic t_off;
    div_window("R2 halted", 3'b000, 0, 400, 3'b000, 0, 400);
  endtask

  task automatic t_div1;
    div_window("R3 undivided", 3'b001, 1, 20, 3'b001, 1, 20);
    // R9: restart pulse during /1 keeps the strobe
    @(negedge clk);
    psc_restart = 1'b1;
    #1 check("R9 restart ignored by /1", cnt_en, 1'b1);
    @(negedge clk);
    psc_restart = 1'b0;
    check("R9 /1 after restart", cnt_en, 1'b1);
  endtask

  task automatic t_divs;
    div_window("R4 /8",   3'b010, 8,   40,  3'b010, 8,   40);
    div_window("R4 /64",  3'b011, 64,  200, 3'b011, 64,  200);
    div_window("R4 /256", 3'b100, 256, 600, 3'b100, 256, 600);
    div_window("R5 /1024", 3'b101, 1024, 2100, 3'b101, 1024, 2100);
  endtask

  task automatic t_restart_mid;
    // R6: run /8, then restart mid-period and expect a fresh phase
    div_window("R6 restart realigns", 3'b010, 8, 13, 3'b010, 8, 13);
    div_window("R6 restart after partial", 3'b011, 64, 100, 3'b011, 64, 100);
  endtask

  task automatic t_switch;
    div_window("R10 /8 to /1024", 3'b010, 8, 20, 3'b101, 1024, 1030);
    div_window("R10 /1024 to /64", 3'b101, 1024, 30, 3'b011, 64, 140);
  endtask

  // Change pin at negedge; strobe expected on the 2nd following negedge only.
  task automatic pin_step(input string req, input logic lvl, input logic expect_pulse,
                          input logic restart_mid);
    int hits = 0;
    int hit_k = -1;
    @(negedge clk);
    ext_clk = lvl;
    for (int k = 1; k <= 6; k++) begin
      @(negedge clk);
      psc_restart = (restart_mid && k == 1);
      if (cnt_en === 1'b1) begin
        hits++;
        if (hit_k < 0) hit_k = k;
      end
    end
    psc_restart = 1'b0;
    n_tests++;
    if (expect_pulse && !(hits == 1 && hit_k == 2)) begin
      n_fail++;
      $display("FAIL %s: pulses=%0d first at %0d expected 1 at 2", req, hits, hit_k);
    end else if (!expect_pulse && hits != 0) begin
      n_fail++;
      $display("FAIL %s: pulses=%0d expected 0", req, hits);
    end
  endtask

  task automatic t_ext_rise;
    @(negedge clk);
    ext_clk = 1'b0;
    src_sel = 3'b111;
    repeat (4) @(negedge clk);
    pin_step("R7 rising counts", 1'b1, 1'b1, 1'b0);
    pin_step("R7 falling ignored", 1'b0, 1'b0, 1'b0);
    pin_step("R9 restart ignored by pin rise", 1'b1, 1'b1, 1'b1);
    pin_step("R7 falling ignored again", 1'b0, 1'b0, 1'b0);
  endtask

  task automatic t_ext_fall;
    @(negedge clk);
    src_sel = 3'b110;
    repeat (4) @(negedge clk);
    pin_step("R8 rising ignored", 1'b1, 1'b0, 1'b0);
    pin_step("R8 falling counts", 1'b0, 1'b1, 1'b0);
    pin_step("R9 restart ignored by pin fall", 1'b1, 1'b0, 1'b1);
    pin_step("R8 falling counts again", 1'b0, 1'b1, 1'b1);
  endtask

  task automatic t_reset_mid;
    @(negedge clk);
    src_sel = 3'b001;
    rst_n = 1'b0;
    @(negedge clk);
    check("R1 reset mid-run", cnt_en, 1'b0);
    src_sel = 3'b000;
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 halted after reset", cnt_en, 1'b0);
  endtask

  initial begin
    #(20 * 200000);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: run did not finish");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_off();
    t_div1();
    t_divs();
    t_restart_mid();
    t_switch();
    t_ext_rise();
    t_ext_fall();
    t_reset_mid();
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule